// File: doc/BRIEF.md
# Root Hub Port Status and Control Registers

This block holds the status/control word of each downstream port of a USB root hub. Software reaches the ports through a small word-addressed window: port `i` sits at window base plus `2*i`. The word mixes three kinds of bits. Some are plain read/write, some only the hardware may change, and two change flags are cleared by writing a one to them. The register also records device attach and detach events from the port's line logic.

Attach and detach arrive as single-cycle pulses per port, together with the device's low-speed indication. Each event updates the connect, change and enable bits. It also raises a one-cycle resume request toward the controller's command/status logic. When software sets the port-reset bit and a device is present, the block sends a one-cycle bus-reset pulse to that device. A per-port enabled flag is brought out so the packet router can skip disabled ports. A controller reset reloads every port word and then re-applies the attach state of any device still present.

Top module: `root_hub_ports`

## Requirements
- R1: After `rst_n` every port word reads 0x0080, `port_enabled` and `bus_reset` are low, and no device is considered present.
- R2: A write to a port changes only bit 2 and bits 15..9, which take the written value. Bits 8..3 and 1..0 keep their old value (mask 0x01FB kept). The new value is readable in the cycle after the write.
- R3: Bit 1 (connect change) and bit 3 (enable change) are cleared by a write whose data has a 1 in that position. A 0 leaves them unchanged.
- R4: `bus_reset[i]` is high for exactly one cycle, in the cycle after a write to port `i` that sets bit 9 while bit 9 was clear and a device was present. There is no pulse when no device is present or bit 9 was already set.
- R5: An attach pulse sets bit 0 (connected) and bit 1 (connect change), and copies `low_speed[i]` into bit 8.
- R6: A detach pulse clears bit 0 and sets bit 1 if bit 0 was set. It clears bit 2 and sets bit 3 if bit 2 was set. Afterwards the port counts as empty.
- R7: `resume_req` is high in the cycle after any attach or detach pulse on any port, or after a controller reset while a device is present.
- R8: Reads of any address that is not an implemented port return 0xFF7F: window offsets 0x14..0x1F with two ports, or addresses outside the window. Writes to such addresses change no port.
- R9: If attach and detach are both pulsed on one port in the same cycle, the detach is applied and the port ends empty.
- R10: `ctrl_reset` reloads 0x0080 into every port and ignores a write in the same cycle. If a device is present, it then sets bits 0 and 1 and loads bit 8 from `low_speed`.
- R11: `port_enabled[i]` always equals bit 2 of port `i`'s word.
- R12: A write and an attach or detach in the same cycle both take effect. The event is applied to the result of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reset | input | 1 | Synchronous controller reset pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 16 | Read data (combinational) |
| attach | input | NPORTS | Device attach pulse per port |
| detach | input | NPORTS | Device detach pulse per port |
| low_speed | input | NPORTS | Device low-speed indication per port |
| bus_reset | output | NPORTS | One-cycle bus-reset pulse per port |
| port_enabled | output | NPORTS | Port enable bit per port |
| resume_req | output | 1 | One-cycle resume request |

## Verification
A wrong kept/writable mask or a missed write-one-to-clear shows in `rd_data` one cycle after the write. A wrong internal presence flag shows up later, and only indirectly. It appears as a missing or spurious `bus_reset` pulse on the next port-reset write, or as a wrong word after a controller reset. For this reason the bench pairs presence changes with both of those stimuli. A wrong event priority shows in the connect bits and `port_enabled` one cycle after the event.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
   localparam int unsigned REG_W = 16;
   localparam int unsigned IDX_W = 3;

   localparam int B_CCS  = 0;
   localparam int B_CSC  = 1;
   localparam int B_EN   = 2;
   localparam int B_ENC  = 3;
   localparam int B_LSDA = 8;
   localparam int B_PRST = 9;

   localparam logic [REG_W-1:0] KEEP_MASK  = 16'h01FB;
   localparam logic [REG_W-1:0] W1C_MASK   = 16'h000A;
   localparam logic [REG_W-1:0] RESET_VAL  = 16'h0080;
   localparam logic [REG_W-1:0] ABSENT_VAL = 16'hFF7F;
endpackage

// File: rtl/rhp_addr_dec.sv
module rhp_addr_dec
   import rhp_pkg::*;
#(
   parameter int unsigned NPORTS = 2,
   parameter int unsigned ADDR_W = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h10
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NPORTS-1:0] wr_sel,
   output logic              rd_hit,
   output logic [IDX_W-1:0]  rd_idx
);
   logic              wr_win, rd_win;
   logic [IDX_W-1:0]  wr_idx;
   logic [NPORTS-1:0] rd_match;
   logic              unused_lsb;

   assign wr_win = (wr_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
   assign rd_win = (rd_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
   assign wr_idx = wr_addr[3:1];
   assign rd_idx = rd_addr[3:1];
   assign unused_lsb = &{1'b0, wr_addr[0], rd_addr[0]};

   for (genvar i = 0; i < NPORTS; i++) begin : g_sel
      assign wr_sel[i]   = wr_en && wr_win && (wr_idx == IDX_W'(i));
      assign rd_match[i] = rd_win && (rd_idx == IDX_W'(i));
   end

   assign rd_hit = |rd_match;
endmodule

// File: rtl/rhp_port_reg.sv
module rhp_port_reg
   import rhp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_reset,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             attach,
   input  logic             detach,
   input  logic             low_speed,
   output logic [REG_W-1:0] ctrl_q,
   output logic             bus_reset,
   output logic             event_now
);
   logic             present_q, present_d;
   logic [REG_W-1:0] merged, ctrl_d;
   logic             pulse_d;

   always_comb begin
      present_d = present_q;
      if (detach)
         present_d = 1'b0;
      else if (attach)
         present_d = 1'b1;
   end

   always_comb begin
      merged = ctrl_q;
      if (wr_sel) begin
         merged = (ctrl_q & KEEP_MASK) | (wr_data & ~KEEP_MASK);
         merged = merged & ~(wr_data & W1C_MASK);
      end
   end

   always_comb begin
      ctrl_d = merged;
      if (detach) begin
         if (merged[B_CCS]) begin
            ctrl_d[B_CCS] = 1'b0;
            ctrl_d[B_CSC] = 1'b1;
         end
         if (merged[B_EN]) begin
            ctrl_d[B_EN]  = 1'b0;
            ctrl_d[B_ENC] = 1'b1;
         end
      end else if (attach) begin
         ctrl_d[B_CCS]  = 1'b1;
         ctrl_d[B_CSC]  = 1'b1;
         ctrl_d[B_LSDA] = low_speed;
      end
      if (ctrl_reset) begin
         ctrl_d = RESET_VAL;
         if (present_d) begin
            ctrl_d[B_CCS]  = 1'b1;
            ctrl_d[B_CSC]  = 1'b1;
            ctrl_d[B_LSDA] = low_speed;
         end
      end
   end

   assign pulse_d   = !ctrl_reset && wr_sel && wr_data[B_PRST] &&
                      !ctrl_q[B_PRST] && present_q;
   assign event_now = attach || detach || (ctrl_reset && present_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= RESET_VAL;
         present_q <= 1'b0;
         bus_reset <= 1'b0;
      end else begin
         ctrl_q    <= ctrl_d;
         present_q <= present_d;
         bus_reset <= pulse_d;
      end
   end
endmodule

// File: rtl/rhp_read_mux.sv
module rhp_read_mux
   import rhp_pkg::*;
#(
   parameter int unsigned NPORTS = 2
) (
   input  logic [NPORTS-1:0][REG_W-1:0] port_q,
   input  logic                         rd_hit,
   input  logic [IDX_W-1:0]             rd_idx,
   output logic [REG_W-1:0]             rd_data
);
   always_comb begin
      rd_data = ABSENT_VAL;
      for (int i = 0; i < NPORTS; i++) begin
         if (rd_hit && (rd_idx == IDX_W'(i)))
            rd_data = port_q[i];
      end
   end
endmodule

// File: rtl/root_hub_ports.sv
module root_hub_ports
   import rhp_pkg::*;
#(
   parameter int unsigned NPORTS = 2,
   parameter int unsigned ADDR_W = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_reset,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [15:0]       rd_data,
   input  logic [NPORTS-1:0] attach,
   input  logic [NPORTS-1:0] detach,
   input  logic [NPORTS-1:0] low_speed,
   output logic [NPORTS-1:0] bus_reset,
   output logic [NPORTS-1:0] port_enabled,
   output logic              resume_req
);
   initial begin
      assert (NPORTS >= 1 && NPORTS <= 8)
         else $error("root_hub_ports: NPORTS must be 1..8");
      assert (ADDR_W >= 5)
         else $error("root_hub_ports: ADDR_W must be at least 5");
      assert (WIN_BASE[3:0] == 4'h0)
         else $error("root_hub_ports: WIN_BASE must be 16-aligned");
   end

   logic [NPORTS-1:0]            wr_sel;
   logic                         rd_hit;
   logic [IDX_W-1:0]             rd_idx;
   logic [NPORTS-1:0][REG_W-1:0] port_q;
   logic [NPORTS-1:0]            evt;

   rhp_addr_dec #(
      .NPORTS  (NPORTS),
      .ADDR_W  (ADDR_W),
      .WIN_BASE(WIN_BASE)
   ) u_dec (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .rd_addr(rd_addr),
      .wr_sel (wr_sel),
      .rd_hit (rd_hit),
      .rd_idx (rd_idx)
   );

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      rhp_port_reg u_reg (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctrl_reset(ctrl_reset),
         .wr_sel    (wr_sel[i]),
         .wr_data   (wr_data),
         .attach    (attach[i]),
         .detach    (detach[i]),
         .low_speed (low_speed[i]),
         .ctrl_q    (port_q[i]),
         .bus_reset (bus_reset[i]),
         .event_now (evt[i])
      );
      assign port_enabled[i] = port_q[i][B_EN];
   end

   rhp_read_mux #(.NPORTS(NPORTS)) u_mux (
      .port_q (port_q),
      .rd_hit (rd_hit),
      .rd_idx (rd_idx),
      .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         resume_req <= 1'b0;
      else
         resume_req <= |evt;
   end
endmodule

// File: rtl/rhp_checker.sv
module rhp_checker #(
   parameter int unsigned NPORTS = 2,
   parameter int unsigned ADDR_W = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE = 'h10
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NPORTS-1:0]       attach,
   input logic [NPORTS-1:0]       detach,
   input logic [NPORTS-1:0]       bus_reset,
   input logic [NPORTS-1:0]       port_enabled,
   input logic                    resume_req,
   input logic [ADDR_W-1:0]       rd_addr,
   input logic [15:0]             rd_data,
   input logic [NPORTS-1:0][15:0] port_q
);
   logic rd_unimpl;
   assign rd_unimpl = (rd_addr[ADDR_W-1:4] != WIN_BASE[ADDR_W-1:4]) ||
                      (32'(rd_addr[3:1]) >= NPORTS);

   // R8
   a_r8_absent_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_unimpl |-> (rd_data == 16'hFF7F));

   // R7
   a_r7_resume_after_event: assert property (@(posedge clk) disable iff (!rst_n)
      ((|attach) || (|detach)) |=> resume_req);

   for (genvar i = 0; i < NPORTS; i++) begin : g_chk
      // R4
      a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         bus_reset[i] |=> !bus_reset[i]);
      // R6
      a_r6_detach_disables: assert property (@(posedge clk) disable iff (!rst_n)
         detach[i] |=> !port_enabled[i]);
      // R5
      a_r5_attach_connects: assert property (@(posedge clk) disable iff (!rst_n)
         (attach[i] && !detach[i]) |=> port_q[i][0]);
      // R9
      a_r9_detach_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (attach[i] && detach[i]) |=> !port_q[i][0]);
   end
endmodule

bind root_hub_ports rhp_checker #(
   .NPORTS  (NPORTS),
   .ADDR_W  (ADDR_W),
   .WIN_BASE(WIN_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .attach      (attach),
   .detach      (detach),
   .bus_reset   (bus_reset),
   .port_enabled(port_enabled),
   .resume_req  (resume_req),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .port_q      (port_q)
);

// File: tb/tb_root_hub_ports.sv
`timescale 1ns/1ps
module tb_root_hub_ports;
   localparam int NP = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_reset = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [4:0]  rd_addr = 5'h10;
   logic [15:0] rd_data;
   logic [NP-1:0] attach = '0, detach = '0, low_speed = '0;
   logic [NP-1:0] bus_reset, port_enabled;
   logic        resume_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [15:0] m_ctrl [NP];
   bit          m_pres [NP];
   bit          m_pulse[NP];
   bit          m_res;

   always #2.5 clk = ~clk;

   root_hub_ports dut (
      .clk(clk), .rst_n(rst_n), .ctrl_reset(ctrl_reset),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .attach(attach), .detach(detach), .low_speed(low_speed),
      .bus_reset(bus_reset), .port_enabled(port_enabled),
      .resume_req(resume_req)
   );

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd(logic [4:0] a);
      if (a[4] && (int'(a[3:1]) < NP)) return m_ctrl[int'(a[3:1])];
      return 16'hFF7F;
   endfunction

   task automatic model_step(bit we, logic [4:0] wa, logic [15:0] wd,
                             logic [NP-1:0] at, logic [NP-1:0] dt,
                             logic [NP-1:0] ls, bit cr);
      bit res = 1'b0;
      for (int i = 0; i < NP; i++) begin
         bit hit = we && wa[4] && (int'(wa[3:1]) == i);
         bit p = m_pres[i];
         logic [15:0] c = m_ctrl[i];
         if (dt[i]) p = 1'b0; else if (at[i]) p = 1'b1;
         m_pulse[i] = !cr && hit && wd[9] && !c[9] && m_pres[i];
         if (hit) begin
            c = (c & 16'h01FB) | (wd & ~16'h01FB);
            c = c & ~(wd & 16'h000A);
         end
         if (dt[i]) begin
            if (c[0]) begin c[0] = 1'b0; c[1] = 1'b1; end
            if (c[2]) begin c[2] = 1'b0; c[3] = 1'b1; end
         end else if (at[i]) begin
            c[0] = 1'b1; c[1] = 1'b1; c[8] = ls[i];
         end
         if (cr) begin
            c = 16'h0080;
            if (p) begin c[0] = 1'b1; c[1] = 1'b1; c[8] = ls[i]; end
         end
         if (at[i] || dt[i] || (cr && p)) res = 1'b1;
         m_ctrl[i] = c;
         m_pres[i] = p;
      end
      m_res = res;
   endtask

   // Called at a falling edge; returns at the next falling edge after checks.
   task automatic cyc(string tag, bit we, logic [4:0] wa, logic [15:0] wd,
                      logic [NP-1:0] at, logic [NP-1:0] dt, logic [NP-1:0] ls,
                      bit cr, logic [4:0] ra);
      wr_en = we; wr_addr = wa; wr_data = wd; attach = at; detach = dt;
      low_speed = ls; ctrl_reset = cr; rd_addr = ra;
      model_step(we, wa, wd, at, dt, ls, cr);
      @(negedge clk);
      check({tag, " rd_data"}, rd_data, exp_rd(ra));
      for (int i = 0; i < NP; i++) begin
         check({tag, " R4 bus_reset"}, 16'(bus_reset[i]), 16'(m_pulse[i]));
         check({tag, " R11 port_enabled"}, 16'(port_enabled[i]), 16'(m_ctrl[i][2]));
      end
      check({tag, " R7 resume_req"}, 16'(resume_req), 16'(m_res));
   endtask

   task automatic idle(string tag, logic [4:0] ra);
      cyc(tag, 1'b0, 5'h0, 16'h0, '0, '0, low_speed, 1'b0, ra);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < NP; i++) begin
         m_ctrl[i] = 16'h0080; m_pres[i] = 1'b0; m_pulse[i] = 1'b0;
      end
      m_res = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of both ports
      check("R1 port0", rd_data, 16'h0080);
      check("R1 enables", 16'(port_enabled), 16'h0);
      idle("R1", 5'h12);
      check("R1 port1", rd_data, 16'h0080);
      // R8: unimplemented offsets
      idle("R8", 5'h14);
      check("R8 offset14", rd_data, 16'hFF7F);
      idle("R8", 5'h00);
      check("R8 outside", rd_data, 16'hFF7F);
      // R2: mask, no device so no pulse (R4)
      cyc("R2", 1'b1, 5'h10, 16'hFFFF, '0, '0, '0, 1'b0, 5'h10);
      check("R2 merge", rd_data, 16'hFE84);
      check("R4 absent no pulse", 16'(bus_reset[0]), 16'h0);
      cyc("R2", 1'b1, 5'h10, 16'h0000, '0, '0, '0, 1'b0, 5'h10);
      check("R2 clear", rd_data, 16'h0080);
      // R5: attach low-speed
      cyc("R5", 1'b0, 5'h0, 16'h0, 2'b01, '0, 2'b01, 1'b0, 5'h10);
      check("R5 attach", rd_data, 16'h0183);
      check("R7 resume", 16'(resume_req), 16'h1);
      // R3: write-one-to-clear
      cyc("R3", 1'b1, 5'h10, 16'h000A, '0, '0, 2'b01, 1'b0, 5'h10);
      check("R3 w1c", rd_data, 16'h0181);
      cyc("R11", 1'b1, 5'h10, 16'h0004, '0, '0, 2'b01, 1'b0, 5'h10);
      check("R11 enable", 16'(port_enabled[0]), 16'h1);
      // R4: port reset pulse then no repeat
      cyc("R4", 1'b1, 5'h10, 16'h0204, '0, '0, 2'b01, 1'b0, 5'h10);
      check("R4 pulse", 16'(bus_reset[0]), 16'h1);
      check("R4 word", rd_data, 16'h0385);
      cyc("R4", 1'b1, 5'h10, 16'h0204, '0, '0, 2'b01, 1'b0, 5'h10);
      check("R4 no repeat", 16'(bus_reset[0]), 16'h0);
      // R9: attach port1, then attach+detach together
      cyc("R9", 1'b0, 5'h0, 16'h0, 2'b10, '0, 2'b01, 1'b0, 5'h12);
      check("R9 pre", rd_data, 16'h0083);
      cyc("R9", 1'b0, 5'h0, 16'h0, 2'b10, 2'b10, 2'b01, 1'b0, 5'h12);
      check("R9 detach wins", rd_data, 16'h0082);
      // R6: detach port0
      cyc("R6", 1'b0, 5'h0, 16'h0, '0, 2'b01, 2'b01, 1'b0, 5'h10);
      check("R6 detach", rd_data, 16'h038A);
      // R8: write to absent port changes nothing
      cyc("R8", 1'b1, 5'h16, 16'hFFFF, '0, '0, '0, 1'b0, 5'h10);
      check("R8 no effect", rd_data, 16'h038A);
      // R12: write and detach together
      cyc("R12", 1'b0, 5'h0, 16'h0, 2'b01, '0, '0, 1'b0, 5'h10);
      check("R12 pre", rd_data, 16'h028B);
      cyc("R12", 1'b1, 5'h10, 16'h0004, '0, 2'b01, '0, 1'b0, 5'h10);
      check("R12 write+detach", rd_data, 16'h008A);
      // R10: controller reset with device present, write ignored
      cyc("R10", 1'b0, 5'h0, 16'h0, 2'b01, '0, 2'b01, 1'b0, 5'h10);
      cyc("R10", 1'b1, 5'h10, 16'hFFFF, '0, '0, 2'b01, 1'b1, 5'h10);
      check("R10 reattach", rd_data, 16'h0183);
      check("R10 resume", 16'(resume_req), 16'h1);
      idle("R10", 5'h12);
      check("R10 empty port", rd_data, 16'h0080);

      // Random phase
      for (int k = 0; k < 3000; k++) begin
         bit we = ($urandom % 2) == 0;
         logic [4:0] wa = ($urandom % 8 == 0) ? 5'($urandom) : {1'b1, 4'($urandom)};
         logic [15:0] wd = 16'($urandom);
         logic [NP-1:0] at, dt;
         for (int i = 0; i < NP; i++) begin
            at[i] = ($urandom % 8) == 0;
            dt[i] = ($urandom % 10) == 0;
         end
         cyc("R2 random", we, wa, wd, at, dt, NP'($urandom),
             ($urandom % 64) == 0, {($urandom % 6) != 0, 4'($urandom)});
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule